// File: doc/BRIEF.md
# Multi-Master Doorbell Controller

This block holds a bank of doorbells, one per bus master that can be signalled. Any master rings a target doorbell by writing its trigger register. Each doorbell keeps an acceptance mask with one bit per master ID. It also keeps a record of every attempted ring, and a pending set of accepted rings that drives that doorbell's interrupt line. The owner of a doorbell reads the pending set to learn which masters rang. It then clears those bits by writing the same value back.

Several write ports reach the bank at once, so rings from different masters and clears from the owner can land in the same cycle. Each write carries the writing master's ID on a sideband input, and that ID picks the bit a ring records. A single read port returns one register per request.

Top module: `dbell_ctrl`

## Requirements
- R1: After reset every mask, attempt and pending register reads zero, every interrupt line is low and the read data output is zero.
- R2: Register offset 0x4 of a doorbell is the acceptance mask; a write stores the low NUM_MASTERS data bits and a read returns them with all higher bits zero.
- R3: A write to offset 0x0 with data bit 0 set, from master m, sets bit m of that doorbell's attempt register (offset 0x8) whatever the mask holds; a write to offset 0x0 with data bit 0 clear changes nothing.
- R4: The same ring sets bit m of the pending register (offset 0xC) only when mask bit m was set before that cycle; a mask write in the same cycle does not affect that ring.
- R5: Writing to offset 0x8 or 0xC clears exactly the register bits written as 1 and leaves the others.
- R6: Each doorbell's interrupt line is high exactly while its pending register is non-zero, and it follows the register with no added delay.
- R7: When a ring and a clear hit the same pending bit in the same cycle, the bit ends set.
- R8: Rings arriving on different ports in one cycle are all recorded; when several ports write the same mask in one cycle, the lowest-numbered port's value is kept.
- R9: Read data appears on the cycle after a read request, reads of offset 0x0 return zero, and read data holds its value while no read is requested.
- R10: Address bits [3:2] select the register (0 trigger, 1 mask, 2 attempt, 3 pending) and bits from 4 upward select the doorbell; an access touches only the selected doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | NUM_PORTS | Write strobe, one per write port |
| wr_addr | input | NUM_PORTS*AW | Byte address per port, port p at bits [p*AW +: AW] |
| wr_data | input | NUM_PORTS*32 | Write data per port, port p at bits [p*32 +: 32] |
| wr_master | input | NUM_PORTS*MIDW | Master ID of the writer per port |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| db_irq | output | NUM_DB | Interrupt per doorbell, high while its pending register is non-zero |

## Verification
A write sampled on a rising edge changes the attempt, pending and mask registers and the interrupt lines at that same edge. A read requested on one edge shows its data after the next edge. The bench drives every access on a falling edge and samples results on the following falling edge, so interrupts are checked half a cycle after the write edge and readback one full cycle after the request. Collision cases (ring with clear, ring with mask write, twin mask writes) are driven on both ports in one cycle, so their results come due together at the next falling edge.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  localparam int DBELL_DATA_W = 32;
  localparam int DBELL_WIN_LSB = 4;

  typedef enum logic [1:0] {
    REG_RING = 2'd0,
    REG_MASK = 2'd1,
    REG_SEEN = 2'd2,
    REG_PEND = 2'd3
  } dbell_reg_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dbell_port_dec.sv
module dbell_port_dec
  import dbell_pkg::*;
#(
  parameter int NUM_DB      = 8,
  parameter int NUM_MASTERS = 8,
  parameter int DBW         = 3,
  parameter int MIDW        = 3,
  parameter int AW          = 7
) (
  input  logic                                  wr_en,
  input  logic [AW-1:0]                         wr_addr,
  input  logic [NUM_MASTERS-1:0]                wr_mdata,
  input  logic [MIDW-1:0]                       wr_master,
  output logic [NUM_DB-1:0][NUM_MASTERS-1:0]    ring_vec,
  output logic [NUM_DB-1:0]                     mask_we,
  output logic [NUM_DB-1:0][NUM_MASTERS-1:0]    seen_clr,
  output logic [NUM_DB-1:0][NUM_MASTERS-1:0]    pend_clr
);

  logic [DBW-1:0]         sel_db;
  dbell_reg_e             sel_reg;
  logic [NUM_MASTERS-1:0] who_oh;
  logic                   unused_low;

  assign sel_db     = wr_addr[AW-1:DBELL_WIN_LSB];
  assign sel_reg    = dbell_reg_e'(wr_addr[3:2]);
  assign unused_low = ^wr_addr[1:0];

  always_comb begin
    for (int m = 0; m < NUM_MASTERS; m++) begin
      who_oh[m] = (wr_master == MIDW'(m));
    end
  end

  for (genvar d = 0; d < NUM_DB; d++) begin : g_db
    logic hit;
    assign hit = wr_en && (sel_db == DBW'(d));
    assign ring_vec[d] = (hit && (sel_reg == REG_RING) && wr_mdata[0]) ? who_oh : '0;
    assign mask_we[d]  = hit && (sel_reg == REG_MASK);
    assign seen_clr[d] = (hit && (sel_reg == REG_SEEN)) ? wr_mdata : '0;
    assign pend_clr[d] = (hit && (sel_reg == REG_PEND)) ? wr_mdata : '0;
  end

endmodule

// File: rtl/dbell_unit.sv
module dbell_unit #(
  parameter int NUM_MASTERS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] ring_vec,
  input  logic                   mask_we,
  input  logic [NUM_MASTERS-1:0] mask_wd,
  input  logic [NUM_MASTERS-1:0] seen_clr,
  input  logic [NUM_MASTERS-1:0] pend_clr,
  output logic [NUM_MASTERS-1:0] mask_q,
  output logic [NUM_MASTERS-1:0] seen_q,
  output logic [NUM_MASTERS-1:0] pend_q,
  output logic                   irq
);

  logic [NUM_MASTERS-1:0] mask_d;
  logic [NUM_MASTERS-1:0] seen_d;
  logic [NUM_MASTERS-1:0] pend_d;
  logic                   upd;

  // Rings are judged against the mask held before this cycle's writes,
  // and a ring is ORed in after the clear so it always survives.
  always_comb begin
    mask_d = mask_we ? mask_wd : mask_q;
    seen_d = (seen_q & ~seen_clr) | ring_vec;
    pend_d = (pend_q & ~pend_clr) | (ring_vec & mask_q);
    upd    = mask_we | (|ring_vec) | (|seen_clr) | (|pend_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      seen_q <= '0;
      pend_q <= '0;
    end else if (upd) begin
      mask_q <= mask_d;
      seen_q <= seen_d;
      pend_q <= pend_d;
    end
  end

  assign irq = |pend_q;

endmodule

// File: rtl/dbell_rd_mux.sv
module dbell_rd_mux
  import dbell_pkg::*;
#(
  parameter int NUM_DB      = 8,
  parameter int NUM_MASTERS = 8,
  parameter int DBW         = 3,
  parameter int AW          = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd_en,
  input  logic [AW-1:0]                      rd_addr,
  input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] mask_q,
  input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] seen_q,
  input  logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_q,
  output logic [DBELL_DATA_W-1:0]            rd_data
);

  logic [DBW-1:0]          rd_db;
  dbell_reg_e              rd_reg;
  logic [DBELL_DATA_W-1:0] rd_nxt;
  logic                    unused_low;

  assign rd_db      = rd_addr[AW-1:DBELL_WIN_LSB];
  assign rd_reg     = dbell_reg_e'(rd_addr[3:2]);
  assign unused_low = ^rd_addr[1:0];

  always_comb begin
    rd_nxt = '0;
    if (int'(rd_db) < NUM_DB) begin
      case (rd_reg)
        REG_MASK: rd_nxt = DBELL_DATA_W'(mask_q[rd_db]);
        REG_SEEN: rd_nxt = DBELL_DATA_W'(seen_q[rd_db]);
        REG_PEND: rd_nxt = DBELL_DATA_W'(pend_q[rd_db]);
        default:  rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_nxt;
    end
  end

endmodule

// File: rtl/dbell_ctrl.sv
module dbell_ctrl
  import dbell_pkg::*;
#(
  parameter int  NUM_DB      = 8,
  parameter int  NUM_MASTERS = 8,
  parameter int  NUM_PORTS   = 2,
  localparam int DBW         = idx_width(NUM_DB),
  localparam int MIDW        = idx_width(NUM_MASTERS),
  localparam int AW          = DBW + DBELL_WIN_LSB
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              wr_en,
  input  logic [NUM_PORTS*AW-1:0]           wr_addr,
  input  logic [NUM_PORTS*DBELL_DATA_W-1:0] wr_data,
  input  logic [NUM_PORTS*MIDW-1:0]         wr_master,
  input  logic                              rd_en,
  input  logic [AW-1:0]                     rd_addr,
  output logic [DBELL_DATA_W-1:0]           rd_data,
  output logic [NUM_DB-1:0]                 db_irq
);

  // Reset: asserted at once, released two clock edges later.
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  logic [NUM_PORTS-1:0][NUM_DB-1:0][NUM_MASTERS-1:0] ring_p;
  logic [NUM_PORTS-1:0][NUM_DB-1:0]                  mask_we_p;
  logic [NUM_PORTS-1:0][NUM_DB-1:0][NUM_MASTERS-1:0] seen_clr_p;
  logic [NUM_PORTS-1:0][NUM_DB-1:0][NUM_MASTERS-1:0] pend_clr_p;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dbell_port_dec #(
      .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS),
      .DBW(DBW), .MIDW(MIDW), .AW(AW)
    ) u_dec (
      .wr_en     (wr_en[p]),
      .wr_addr   (wr_addr[p*AW +: AW]),
      .wr_mdata  (wr_data[p*DBELL_DATA_W +: NUM_MASTERS]),
      .wr_master (wr_master[p*MIDW +: MIDW]),
      .ring_vec  (ring_p[p]),
      .mask_we   (mask_we_p[p]),
      .seen_clr  (seen_clr_p[p]),
      .pend_clr  (pend_clr_p[p])
    );
  end

  logic [NUM_DB-1:0][NUM_MASTERS-1:0] ring_all;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0] seen_clr_all;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_clr_all;
  logic [NUM_DB-1:0]                  mask_we_all;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0] mask_wd_all;

  // Merge ports: rings and clears OR together; for mask writes the
  // loop runs downward so the lowest-numbered port is applied last.
  always_comb begin
    ring_all     = '0;
    seen_clr_all = '0;
    pend_clr_all = '0;
    mask_we_all  = '0;
    mask_wd_all  = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      ring_all     = ring_all | ring_p[p];
      seen_clr_all = seen_clr_all | seen_clr_p[p];
      pend_clr_all = pend_clr_all | pend_clr_p[p];
      for (int d = 0; d < NUM_DB; d++) begin
        if (mask_we_p[p][d]) begin
          mask_we_all[d] = 1'b1;
          mask_wd_all[d] = wr_data[p*DBELL_DATA_W +: NUM_MASTERS];
        end
      end
    end
  end

  logic [NUM_DB-1:0][NUM_MASTERS-1:0] mask_q;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0] seen_q;
  logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_q;

  for (genvar d = 0; d < NUM_DB; d++) begin : g_db
    dbell_unit #(.NUM_MASTERS(NUM_MASTERS)) u_unit (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .ring_vec (ring_all[d]),
      .mask_we  (mask_we_all[d]),
      .mask_wd  (mask_wd_all[d]),
      .seen_clr (seen_clr_all[d]),
      .pend_clr (pend_clr_all[d]),
      .mask_q   (mask_q[d]),
      .seen_q   (seen_q[d]),
      .pend_q   (pend_q[d]),
      .irq      (db_irq[d])
    );
  end

  dbell_rd_mux #(
    .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS), .DBW(DBW), .AW(AW)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .mask_q  (mask_q),
    .seen_q  (seen_q),
    .pend_q  (pend_q),
    .rd_data (rd_data)
  );

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

endmodule

// File: rtl/dbell_ctrl_chk.sv
module dbell_ctrl_chk
  import dbell_pkg::*;
#(
  parameter int  NUM_DB      = 8,
  parameter int  NUM_MASTERS = 8,
  parameter int  NUM_PORTS   = 2,
  localparam int DBW         = idx_width(NUM_DB),
  localparam int MIDW        = idx_width(NUM_MASTERS),
  localparam int AW          = DBW + DBELL_WIN_LSB
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_PORTS-1:0]               wr_en,
  input logic [NUM_PORTS*AW-1:0]            wr_addr,
  input logic [NUM_PORTS*DBELL_DATA_W-1:0]  wr_data,
  input logic [NUM_PORTS*MIDW-1:0]          wr_master,
  input logic                               rd_en,
  input logic [DBELL_DATA_W-1:0]            rd_data,
  input logic [NUM_DB-1:0]                  db_irq,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] mask_q,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] seen_q,
  input logic [NUM_DB-1:0][NUM_MASTERS-1:0] pend_q
);

  logic [DBW-1:0]  d0, d0_q;
  logic [MIDW-1:0] m0, m0_q;
  logic            ring0_ok;

  assign d0 = wr_addr[AW-1:DBELL_WIN_LSB];
  assign m0 = wr_master[MIDW-1:0];
  assign ring0_ok = wr_en[0] && (wr_addr[3:2] == 2'b00) && wr_data[0] &&
                    (int'(d0) < NUM_DB) && (int'(m0) < NUM_MASTERS) &&
                    mask_q[d0][m0];

  always_ff @(posedge clk) begin
    d0_q <= d0;
    m0_q <= m0;
  end

  // R1: leaving reset, nothing is pending and no read data is shown
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (db_irq == '0) && (rd_data == '0));

  // R7: an accepted ring on port 0 is present next cycle, clears or not
  p_ring_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ring0_ok |=> pend_q[d0_q][m0_q]);

  // R9: read data moves only on a read request
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  for (genvar d = 0; d < NUM_DB; d++) begin : g_d
    // R6: an interrupt can only drop after some write cleared it
    p_irq_fall_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(db_irq[d]) |-> $past(|wr_en));
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_m
      // R4: a pending bit only appears if its mask bit was set before
      p_pend_needs_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[d][m]) |-> $past(mask_q[d][m]));
      // R3: an accepted ring is recorded as an attempt too
      p_pend_implies_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[d][m]) |-> seen_q[d][m]);
    end
  end

  logic unused_chk;
  assign unused_chk = ^{wr_en, wr_addr, wr_data, wr_master};

endmodule

bind dbell_ctrl dbell_ctrl_chk #(
  .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS), .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_master (wr_master),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .db_irq    (db_irq),
  .mask_q    (mask_q),
  .seen_q    (seen_q),
  .pend_q    (pend_q)
);

// File: tb/dbell_ctrl_tb.sv
`timescale 1ns/1ps
module dbell_ctrl_tb;

  localparam int ND = 8;
  localparam int NM = 8;
  localparam int NP = 2;
  localparam int AW = 7;
  localparam int MW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [NP-1:0]   wr_en;
  logic [NP*AW-1:0] wr_addr;
  logic [NP*32-1:0] wr_data;
  logic [NP*MW-1:0] wr_master;
  logic            rd_en;
  logic [AW-1:0]   rd_addr;
  logic [31:0]     rd_data;
  logic [ND-1:0]   db_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NM-1:0] m_en   [ND];
  logic [NM-1:0] m_seen [ND];
  logic [NM-1:0] m_pend [ND];

  dbell_ctrl #(.NUM_DB(ND), .NUM_MASTERS(NM), .NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_master(wr_master), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .db_irq(db_irq)
  );

  // R10 address layout: doorbell index from bit 4, register in [3:2]
  function automatic logic [AW-1:0] addr_of(int d, int r);
    return AW'((d << 4) | (r << 2));
  endfunction

  function automatic logic [ND-1:0] exp_irq();
    logic [ND-1:0] v;
    for (int d = 0; d < ND; d++) v[d] = |m_pend[d];
    return v;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_port(int p, int d, int r, logic [31:0] data, int mid);
    wr_en[p] = 1'b1;
    wr_addr[p*AW +: AW] = addr_of(d, r);
    wr_data[p*32 +: 32] = data;
    wr_master[p*MW +: MW] = MW'(mid);
  endtask

  task automatic commit();
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic rd(int d, int r, output logic [31:0] v);
    rd_en = 1'b1;
    rd_addr = addr_of(d, r);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic check_db(string req, int d);
    logic [31:0] v;
    rd(d, 2, v);
    chk(req, $sformatf("attempt db%0d", d), v, 32'(m_seen[d]));
    rd(d, 3, v);
    chk(req, $sformatf("pending db%0d", d), v, 32'(m_pend[d]));
    chk("R6", $sformatf("irq after db%0d", d), 32'(db_irq), 32'(exp_irq()));
  endtask

  task automatic ring(int p, int d, int m);
    set_port(p, d, 0, 32'h1, m);
    commit();
    m_seen[d][m] = 1'b1;
    if (m_en[d][m]) m_pend[d][m] = 1'b1;
  endtask

  task automatic clear(int d, int r, logic [NM-1:0] bits);
    set_port(0, d, r, 32'(bits), 0);
    commit();
    if (r == 2) m_seen[d] = m_seen[d] & ~bits;
    else        m_pend[d] = m_pend[d] & ~bits;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, hold;
    rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0; wr_master = '0;
    rd_en = 1'b0; rd_addr = '0;
    for (int d = 0; d < ND; d++) begin
      m_en[d] = '0; m_seen[d] = '0; m_pend[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: everything zero after reset
    chk("R1", "irq", 32'(db_irq), 32'h0);
    chk("R1", "rd_data", rd_data, 32'h0);
    for (int d = 0; d < ND; d++)
      for (int r = 0; r < 4; r++) begin
        rd(d, r, v);
        chk("R1", $sformatf("reg db%0d off%0d", d, r), v, 32'h0);
      end

    // R3: trigger with data bit 0 clear is ignored
    set_port(0, 0, 0, 32'hFFFF_FFFE, 7);
    commit();
    check_db("R3", 0);

    // R2: mask write keeps low bits only
    for (int d = 0; d < ND; d++) begin
      logic [NM-1:0] pat;
      pat = NM'(d * 37 + 5);
      set_port(d % 2, d, 1, {24'hA5C3E1, pat}, 0);
      commit();
      m_en[d] = pat;
      rd(d, 1, v);
      chk("R2", $sformatf("mask db%0d", d), v, 32'(pat));
    end
    // R10: each doorbell kept its own mask
    for (int d = 0; d < ND; d++) begin
      rd(d, 1, v);
      chk("R10", $sformatf("mask reread db%0d", d), v, 32'(m_en[d]));
    end

    // R3/R4/R6: every master rings every doorbell
    for (int d = 0; d < ND; d++) begin
      for (int m = 0; m < NM; m++) begin
        ring(m % 2, d, m);
        chk("R6", $sformatf("irq ring db%0d m%0d", d, m), 32'(db_irq), 32'(exp_irq()));
      end
      check_db("R4", d);
    end

    // R5: partial then full write-1-to-clear
    for (int d = 0; d < ND; d++) begin
      clear(d, 3, m_pend[d] & 8'h0F);
      clear(d, 2, 8'hF0);
      check_db("R5", d);
      clear(d, 3, 8'hFF);
      clear(d, 2, 8'hFF);
      check_db("R5", d);
    end
    chk("R6", "irq all clear", 32'(db_irq), 32'h0);

    // R7: ring and clear of the same bit in one cycle
    set_port(0, 2, 1, 32'hFF, 0); commit(); m_en[2] = 8'hFF;
    ring(0, 2, 1);
    set_port(0, 2, 0, 32'h1, 5);
    set_port(1, 2, 3, 32'hFF, 0);
    commit();
    m_seen[2][5] = 1'b1;
    m_pend[2] = 8'h20;
    check_db("R7", 2);

    // R8: twin mask writes, port 0 wins
    set_port(0, 4, 1, 32'h3C, 0);
    set_port(1, 4, 1, 32'hC3, 0);
    commit();
    m_en[4] = 8'h3C;
    rd(4, 1, v);
    chk("R8", "mask priority", v, 32'h3C);
    // R8: two rings in one cycle, only the enabled one goes pending
    set_port(0, 4, 0, 32'h1, 2);
    set_port(1, 4, 0, 32'h1, 6);
    commit();
    m_seen[4] = m_seen[4] | 8'h44;
    m_pend[4] = m_pend[4] | 8'h04;
    check_db("R8", 4);

    // R4: ring in the same cycle as a mask write uses the old mask
    set_port(0, 5, 1, 32'hFF, 0);
    set_port(1, 5, 0, 32'h1, 0);
    commit();
    m_seen[5][0] = 1'b1;
    m_en[5] = 8'hFF;
    check_db("R4", 5);

    // R9: trigger reads zero, data holds without a request
    rd(2, 0, v);
    chk("R9", "trigger read", v, 32'h0);
    rd(1, 1, hold);
    set_port(0, 1, 1, 32'h99, 0); commit(); m_en[1] = 8'h99;
    repeat (2) @(negedge clk);
    chk("R9", "hold", rd_data, hold);
    rd(1, 1, v);
    chk("R9", "new read", v, 32'h99);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule